// File: doc/BRIEF.md
# Per-Pin Programmable Glitch Filter

This block cleans one asynchronous input pin before interrupt and level-sensing logic uses it. The raw pin first passes through a two-flop synchronizer. A qualification timer then decides when the cleaned output may take on a new level. The timer counts strobes of a slow real-time clock (`rtc_tick`, one system-clock cycle wide) in programmable units. The unit is a multiple of the real-time clock, chosen by two select bits, and a 4-bit count of units sets the total hold time.

A 2-bit mode selects the behaviour. The filter can be bypassed. It can qualify transitions in both directions, which suits edge-triggered use. It can also qualify only one direction and let the other direction through at once. Delaying only the rising edge removes short high pulses and suits active-high level use. Delaying only the falling edge removes short low pulses and suits active-low level use. Any change to the configuration restarts the timer, and the output keeps its current level while the timer restarts.

Top module: `pin_glitch_filter`

## Requirements
- R1: While `rst_n` is low the output `pin_clean` is 0.
- R2: With `filt_mode` = 00 (bypass) the output follows the raw pin with a latency of exactly three clock edges: two synchronizer stages and the output register.
- R3: The unit select `{unit_large, unit_fine}` picks the unit length in real-time-clock strobes: 00 gives UNIT_00, 01 gives UNIT_01, 10 gives UNIT_10 and 11 gives UNIT_11 (defaults 2, 8, 512, 2048).
- R4: A qualified transition appears on the output at the clock edge of the N×U-th `rtc_tick` counted after the synchronized input first differs from the output. N is `unit_count` with 0 read as 1, and U is the selected unit length. No change occurs on any earlier strobe.
- R5: With `filt_mode` = 11 both rising and falling transitions are qualified as in R4.
- R6: With `filt_mode` = 01 rising transitions are qualified, and falling transitions reach the output one edge after the synchronizer, with no wait.
- R7: With `filt_mode` = 10 falling transitions are qualified, and rising transitions reach the output one edge after the synchronizer, with no wait.
- R8: If the synchronized input returns to the output level before qualification completes, the output does not change, and a later attempt needs the full N×U strobes again.
- R9: A change to any of `filt_mode`, `unit_large`, `unit_fine` or `unit_count` keeps the output level and restarts the timer from zero under the new settings.
- R10: Only clock cycles with `rtc_tick` high advance the timer. Idle cycles between strobes, however many, have no effect on when the output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, deasserted synchronously upstream |
| rtc_tick | input | 1 | One-cycle strobe per real-time-clock period, synchronous to clk |
| pin_raw | input | 1 | Asynchronous pin level |
| filt_mode | input | 2 | 00 bypass, 01 qualify rising only, 10 qualify falling only, 11 qualify both |
| unit_large | input | 1 | Upper unit select bit |
| unit_fine | input | 1 | Lower unit select bit |
| unit_count | input | 4 | Hold time in units, 0 read as 1 |
| pin_clean | output | 1 | Filtered pin level |

## Verification
The embedded properties assume three things about the inputs. `rtc_tick`, the mode, the unit select and the count are all synchronous to `clk`. `rtc_tick` is a single-cycle strobe. The reset has already been synchronized, so only `pin_raw` is truly asynchronous. The bench meets these assumptions by changing every input just after a falling clock edge. It issues each strobe as a one-cycle pulse followed by at least one idle cycle. It changes the configuration only through a dedicated step, so each settings change lands on exactly one rising edge.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

  typedef enum logic [1:0] {
    PGF_BYPASS    = 2'b00,
    PGF_KEEP_LOW  = 2'b01,
    PGF_KEEP_HIGH = 2'b10,
    PGF_QUAL_BOTH = 2'b11
  } pgf_mode_e;

  function automatic int pgf_max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_async;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pgf_prescale.sv
module pgf_prescale #(
  parameter int UNIT_00 = 2,
  parameter int UNIT_01 = 8,
  parameter int UNIT_10 = 512,
  parameter int UNIT_11 = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rtc_tick,
  input  logic       clr,
  input  logic [1:0] unit_sel,
  output logic       unit_tick
);

  localparam int UMAX = pgf_pkg::pgf_max4(UNIT_00, UNIT_01, UNIT_10, UNIT_11);
  localparam int PW   = (UMAX > 2) ? $clog2(UMAX) : 1;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] pcnt_d;
  logic [PW-1:0] term;
  logic          last;
  logic          pcnt_en;

  always_comb begin
    case (unit_sel)
      2'b00:   term = PW'(UNIT_00 - 1);
      2'b01:   term = PW'(UNIT_01 - 1);
      2'b10:   term = PW'(UNIT_10 - 1);
      default: term = PW'(UNIT_11 - 1);
    endcase
  end

  assign last      = (pcnt_q == term);
  assign unit_tick = rtc_tick && last;
  assign pcnt_en   = clr || rtc_tick;

  always_comb begin
    if (clr)       pcnt_d = '0;
    else if (last) pcnt_d = '0;
    else           pcnt_d = pcnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  // R9: a restart always leaves the prescaler at zero
  assert_clr_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt_q == '0));

  // R10: without a strobe or restart the prescaler holds
  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtc_tick && !clr) |=> $stable(pcnt_q));

endmodule

// File: rtl/pgf_core.sv
module pgf_core #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_sync,
  input  logic             unit_tick,
  input  logic [1:0]       mode,
  input  logic [1:0]       unit_sel,
  input  logic [CNT_W-1:0] hold_count,
  output logic             clr,
  output logic             lvl_out
);

  import pgf_pkg::*;

  localparam int CFG_W = 4 + CNT_W;

  pgf_mode_e        mode_e;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_now;
  logic             cfg_chg;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] ucnt_q;
  logic [CNT_W-1:0] ucnt_d;
  logic             ucnt_en;
  logic             out_d;
  logic             pending;
  logic             qualify_dir;
  logic             immediate;
  logic             qual_done;
  logic             out_chg;

  assign mode_e  = pgf_mode_e'(mode);
  assign cfg_now = {mode, unit_sel, hold_count};
  assign cfg_chg = (cfg_now != cfg_q);
  assign need    = (hold_count == '0) ? CNT_W'(1) : hold_count;
  assign pending = (lvl_sync != lvl_out);

  always_comb begin
    case (mode_e)
      PGF_KEEP_LOW:  qualify_dir = lvl_sync;
      PGF_KEEP_HIGH: qualify_dir = !lvl_sync;
      PGF_QUAL_BOTH: qualify_dir = 1'b1;
      default:       qualify_dir = 1'b0;
    endcase
  end

  assign immediate = pending && !qualify_dir;
  assign qual_done = pending && qualify_dir && !cfg_chg && unit_tick
                     && (ucnt_q == need - CNT_W'(1));
  assign out_chg   = immediate || qual_done;
  assign clr       = !pending || cfg_chg || out_chg;

  always_comb begin
    out_d   = out_chg ? lvl_sync : lvl_out;
    ucnt_en = clr || unit_tick;
    ucnt_d  = clr ? '0 : (ucnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ucnt_q  <= '0;
      lvl_out <= 1'b0;
    end else begin
      cfg_q   <= cfg_now;
      lvl_out <= out_d;
      if (ucnt_en) ucnt_q <= ucnt_d;
    end
  end

  // R2: bypass copies the synchronized level one edge later
  assert_bypass_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (lvl_out == $past(lvl_sync)));

  // R6: falling edges are not delayed in mode 01
  assert_fall_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && lvl_out && !lvl_sync) |=> !lvl_out);

  // R7: rising edges are not delayed in mode 10
  assert_rise_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !lvl_out && lvl_sync) |=> lvl_out);

  // R5: in mode 11 the output moves only on a unit boundary
  assert_both_waits_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !unit_tick) |=> $stable(lvl_out));

  // R9: a settings change never releases a qualified transition
  assert_cfg_keeps_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg && mode == 2'b11) |=> $stable(lvl_out));

endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int UNIT_00     = 2,
  parameter int UNIT_01     = 8,
  parameter int UNIT_10     = 512,
  parameter int UNIT_11     = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_tick,
  input  logic             pin_raw,
  input  logic [1:0]       filt_mode,
  input  logic             unit_large,
  input  logic             unit_fine,
  input  logic [CNT_W-1:0] unit_count,
  output logic             pin_clean
);

  logic       lvl_sync;
  logic       unit_tick;
  logic       tmr_clr;
  logic [1:0] unit_sel;

  assign unit_sel = {unit_large, unit_fine};

  pgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_raw),
    .q_sync  (lvl_sync)
  );

  pgf_prescale #(
    .UNIT_00 (UNIT_00),
    .UNIT_01 (UNIT_01),
    .UNIT_10 (UNIT_10),
    .UNIT_11 (UNIT_11)
  ) u_prescale (
    .clk       (clk),
    .rst_n     (rst_n),
    .rtc_tick  (rtc_tick),
    .clr       (tmr_clr),
    .unit_sel  (unit_sel),
    .unit_tick (unit_tick)
  );

  pgf_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_sync   (lvl_sync),
    .unit_tick  (unit_tick),
    .mode       (filt_mode),
    .unit_sel   (unit_sel),
    .hold_count (unit_count),
    .clr        (tmr_clr),
    .lvl_out    (pin_clean)
  );

endmodule

// File: tb/tb_pin_glitch_filter.sv
`timescale 1ns/1ps
module tb_pin_glitch_filter;

  localparam int BU0 = 2;
  localparam int BU1 = 3;
  localparam int BU2 = 4;
  localparam int BU3 = 5;
  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rtc_tick;
  logic       pin_raw;
  logic [1:0] filt_mode;
  logic       unit_large;
  logic       unit_fine;
  logic [3:0] unit_count;
  logic       pin_clean;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pin_glitch_filter #(
    .UNIT_00 (BU0), .UNIT_01 (BU1), .UNIT_10 (BU2), .UNIT_11 (BU3)
  ) dut (
    .clk (clk), .rst_n (rst_n), .rtc_tick (rtc_tick), .pin_raw (pin_raw),
    .filt_mode (filt_mode), .unit_large (unit_large), .unit_fine (unit_fine),
    .unit_count (unit_count), .pin_clean (pin_clean)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      fails++;
      $display("FAIL all-requirements watchdog: got %0d cycles expected <= %0d", cycles, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic t);
    rtc_tick = t;
    @(negedge clk);
    rtc_tick = 1'b0;
  endtask

  function automatic int unit_of(input int sel);
    case (sel)
      0:       return BU0;
      1:       return BU1;
      2:       return BU2;
      default: return BU3;
    endcase
  endfunction

  function automatic int ticks_for(input int sel, input int cnt);
    return ((cnt == 0) ? 1 : cnt) * unit_of(sel);
  endfunction

  task automatic set_cfg(input int m, input int sel, input int cnt);
    filt_mode  = 2'(m);
    unit_large = sel[1];
    unit_fine  = sel[0];
    unit_count = 4'(cnt);
    step(1'b0);
  endtask

  // wait k strobes for newv to appear, checking just before and at the k-th
  task automatic measure(input logic newv, input int k, input int gap, input string req);
    for (int i = 0; i < k - 1; i++) begin
      step(1'b1);
      repeat (gap) step(1'b0);
    end
    check(pin_clean, !newv, req, "level before final strobe");
    step(1'b1);
    check(pin_clean, newv, req, "level at final strobe");
    repeat (gap) step(1'b0);
  endtask

  task automatic qualified_edge(input logic newv, input int k, input int gap, input string req);
    pin_raw = newv;
    repeat (3) step(1'b0);
    measure(newv, k, gap, req);
  endtask

  task automatic direct_edge(input logic newv, input string req);
    pin_raw = newv;
    step(1'b0);
    step(1'b0);
    check(pin_clean, !newv, req, "level after two edges");
    step(1'b0);
    check(pin_clean, newv, req, "level after three edges");
  endtask

  initial begin
    rst_n = 1'b0; rtc_tick = 1'b0; pin_raw = 1'b0;
    filt_mode = 2'b00; unit_large = 1'b0; unit_fine = 1'b0; unit_count = 4'd0;
    repeat (3) @(negedge clk);
    check(pin_clean, 1'b0, "R1", "reset level");
    pin_raw = 1'b1;
    repeat (3) @(negedge clk);
    check(pin_clean, 1'b0, "R1", "level held in reset with pin high");
    pin_raw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) step(1'b0);

    // R2 bypass latency
    direct_edge(1'b1, "R2");
    direct_edge(1'b0, "R2");

    // sweep over every qualifying mode, unit and count
    for (int m = 1; m < 4; m++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int cnt = 0; cnt < 16; cnt++) begin
          int k;
          k = ticks_for(sel, cnt);
          set_cfg(m, sel, cnt);
          if (m[0]) qualified_edge(1'b1, k, 1, (m == 3) ? "R5/R3/R4" : "R6/R3/R4");
          else      direct_edge(1'b1, "R7");
          if (m[1]) qualified_edge(1'b0, k, 1, (m == 3) ? "R5/R3/R4" : "R7/R3/R4");
          else      direct_edge(1'b0, "R6");
        end
      end
    end

    // R8 interrupted attempt is discarded and restarts from zero
    set_cfg(3, 1, 3);
    pin_raw = 1'b1;
    repeat (3) step(1'b0);
    for (int i = 0; i < 8; i++) begin step(1'b1); step(1'b0); end
    pin_raw = 1'b0;
    repeat (3) step(1'b0);
    for (int i = 0; i < 12; i++) begin step(1'b1); step(1'b0); end
    check(pin_clean, 1'b0, "R8", "short high pulse removed");
    qualified_edge(1'b1, 9, 1, "R8");
    qualified_edge(1'b0, 9, 1, "R8");

    // R9 settings change mid-attempt restarts timer and keeps output
    set_cfg(3, 0, 4);
    pin_raw = 1'b1;
    repeat (3) step(1'b0);
    for (int i = 0; i < 7; i++) begin step(1'b1); step(1'b0); end
    set_cfg(3, 0, 6);
    check(pin_clean, 1'b0, "R9", "level kept across settings change");
    measure(1'b1, 12, 1, "R9");
    qualified_edge(1'b0, 12, 1, "R9");

    // R10 idle cycles between strobes do not count
    set_cfg(3, 2, 2);
    qualified_edge(1'b1, 8, 4, "R10");
    pin_raw = 1'b0;
    repeat (3) step(1'b0);
    for (int i = 0; i < 7; i++) begin step(1'b1); step(1'b0); end
    repeat (30) step(1'b0);
    check(pin_clean, 1'b1, "R10", "long idle stretch alone");
    step(1'b1);
    check(pin_clean, 1'b0, "R10", "final strobe after idle stretch");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule